// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block lets a host controller configure a lighting and power controller over a two-wire serial bus. It runs on the system clock and samples the bus lines, so the bus clock must be much slower than the system clock. Each line passes through a two-flop synchroniser and a glitch filter before its edges are detected. From the filtered lines the block finds START, repeated START and STOP conditions. It compares the 7-bit device address 0x4C and then accepts single-byte register writes or random reads. It pulls the data line low through an open-drain enable and never drives it high.

Behind the bus logic sits a small sparse register map with fixed addresses. Six plain byte registers serve as brightness and audio settings. Three 4-bit control registers hold non-zero reset values. A test register combines a writable enable bit with read-only pass/fail bits, and a write that sets its enable bit also fires a one-cycle self-test trigger. All register contents appear on output ports for the surrounding logic.

Top module: `ctrl_i2c_slave`

## Requirements
- R1: While `rstN` is low and right after it, the map holds its defaults. Registers 0x00–0x04 and 0x2A hold 0x00. Register 0x0B holds 0x04: bit0 standby release, bit1 boost enable, bit2 auto-load, bit3 frequency select. Register 0x0D holds 0x07 and register 0x2B holds 0x03. The bit0 test enable of register 0x0C is 0.
- R2: Only the device address 0x4C is acknowledged, with R/W bit 0 for write and 1 for read. After any other address, the block leaves SDA alone until the next START and changes no register.
- R3: A write uses three bytes: the device address with W, the register address, then the data. The slave acknowledges each byte by holding SDA low during the 9th clock, and the addressed register takes the data byte.
- R4: A random read writes the register address, then sends a repeated START and the device address with R. The slave then sends the register's byte MSB first, and a repeated START works exactly like a first START.
- R5: A data byte written to an unmapped address is not acknowledged and changes nothing. A read of an unmapped address returns 0x00.
- R6: Register 0x0C reads as {2'b00, `testStatus[4:0]`, test enable}. Bits 5:1 are read-only and writes to them have no effect.
- R7: A write to register 0x0C with data bit0 = 1 pulses `testStart` high for exactly one clock. A write with bit0 = 0 gives no pulse.
- R8: Registers 0x0B, 0x0D and 0x2B store only their low nibble, and their upper four bits read as 0.
- R9: `sdaOe` changes only while SCL is low.
- R10: A STOP at any point returns the slave to idle. A transaction cut short before its data byte changes no register.
- R11: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| testStatus | input | 5 | Pass/fail bits from the LED test, read back in register 0x0C |
| sdaOe | output | 1 | When high, the pad pulls the data line low |
| bankRegs | output | 48 | Byte registers 0x00–0x04 in bytes 0–4, register 0x2A in byte 5 |
| enables | output | 4 | Contents of register 0x0B |
| boostCode | output | 4 | Contents of register 0x0D |
| threshold | output | 4 | Contents of register 0x2B |
| testEn | output | 1 | Test enable bit of register 0x0C |
| testStart | output | 1 | One-clock self-test trigger |

## Verification
The assertions assume a well-behaved master. Each SCL low phase lasts longer than the synchroniser and filter delay, so the slave's reaction to a falling edge lands before SCL rises again. The master changes SDA only while SCL is low, except when it makes a START or a STOP. The bench drives SCL with 20-cycle half periods, several times the filter delay. Its only deliberately illegal event is a 2-cycle SCL glitch placed inside a low phase, and it keeps the master's SDA released whenever the slave is expected to drive.

// File: rtl/i2c_slave_pkg.sv
`timescale 1ns/1ps
package i2c_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 5;
  typedef logic [BYTE_W-1:0] byte_t;

  // Strobes from the bus controller into the register datapath
  typedef struct packed {
    logic  wr;
    byte_t addr;
    byte_t data;
  } regCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WDATA, ST_ACK, ST_RDATA, ST_MACK, ST_WAIT
  } busState_t;
endpackage

// File: rtl/i2c_bus_ctrl.sv
`timescale 1ns/1ps
module i2c_bus_ctrl import i2c_slave_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         FILT_LEN    = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  byte_t   rdData,
  input  logic    addrHit,
  output logic    sdaOe,
  output regCmd_t cmd
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam int LINES = 2;

  logic [LINES-1:0] rawIn;
  logic [LINES-1:0] filt;
  logic [LINES-1:0] filtQ;
  assign rawIn = {sdaIn, sclIn};

  // Per-line synchroniser and glitch filter
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;
    logic [CNT_W-1:0]       cnt;
    logic                   lineQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        cnt   <= '0;
        lineQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn[g]};
        if (syncQ[SYNC_STAGES-1] != lineQ) begin
          if (cnt == CNT_W'(FILT_LEN - 1)) begin
            lineQ <= syncQ[SYNC_STAGES-1];
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
    assign filt[g] = lineQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtQ <= '1;
    else       filtQ <= filt;
  end

  logic sclRise, sclFall, sdaRise, sdaFall, startDet, stopDet;
  assign sclRise  = filt[0] & ~filtQ[0];
  assign sclFall  = ~filt[0] & filtQ[0];
  assign sdaRise  = filt[1] & ~filtQ[1];
  assign sdaFall  = ~filt[1] & filtQ[1];
  assign startDet = filt[0] & filtQ[0] & sdaFall;
  assign stopDet  = filt[0] & filtQ[0] & sdaRise;

  busState_t state, nextSt;
  logic [3:0] bitCnt;
  byte_t      rxShift, txShift, ptr, wrByte;
  logic       sdaOeQ, wrPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nextSt  <= ST_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
      wrByte  <= '0;
      sdaOeQ  <= 1'b0;
      wrPulse <= 1'b0;
    end else begin
      wrPulse <= 1'b0;
      if (startDet) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        sdaOeQ <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        sdaOeQ <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_REG, ST_WDATA: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], filt[1]};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_DEV) begin
                if (rxShift[7:1] == DEV_ADDR) begin
                  sdaOeQ <= 1'b1;
                  state  <= ST_ACK;
                  nextSt <= rxShift[0] ? ST_RDATA : ST_REG;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_REG) begin
                ptr    <= rxShift;
                sdaOeQ <= 1'b1;
                state  <= ST_ACK;
                nextSt <= ST_WDATA;
              end else begin
                if (addrHit) begin
                  wrPulse <= 1'b1;
                  wrByte  <= rxShift;
                  sdaOeQ  <= 1'b1;
                  state   <= ST_ACK;
                  nextSt  <= ST_WAIT;
                end else begin
                  state <= ST_WAIT;
                end
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              state <= nextSt;
              if (nextSt == ST_RDATA) begin
                txShift <= rdData;
                sdaOeQ  <= ~rdData[7];
              end else begin
                sdaOeQ <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOeQ <= 1'b0;
                bitCnt <= '0;
                state  <= ST_MACK;
              end else begin
                sdaOeQ  <= ~txShift[6];
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: if (sclFall) state <= ST_WAIT;
          default: ;
        endcase
      end
    end
  end

  assign sdaOe    = sdaOeQ;
  assign cmd.wr   = wrPulse;
  assign cmd.addr = ptr;
  assign cmd.data = wrByte;
endmodule

// File: rtl/i2c_reg_file.sv
`timescale 1ns/1ps
module i2c_reg_file import i2c_slave_pkg::*; #(
  parameter int BANK_N = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regCmd_t                   cmd,
  input  logic [STAT_W-1:0]         testStatus,
  output byte_t                     rdData,
  output logic                      addrHit,
  output logic [(BANK_N+1)*8-1:0]   bankRegs,
  output logic [3:0]                enables,
  output logic [3:0]                boostCode,
  output logic [3:0]                threshold,
  output logic                      testEn,
  output logic                      testStart
);
  localparam int    SLOT_N      = BANK_N + 1;
  localparam byte_t ADDR_ENABLE = 8'h0B;
  localparam byte_t ADDR_TEST   = 8'h0C;
  localparam byte_t ADDR_BOOST  = 8'h0D;
  localparam byte_t ADDR_AUDIO  = 8'h2A;
  localparam byte_t ADDR_THRESH = 8'h2B;
  localparam logic [3:0] ENABLE_RST = 4'b0100;
  localparam logic [3:0] BOOST_RST  = 4'b0111;
  localparam logic [3:0] THRESH_RST = 4'b0011;

  function automatic byte_t slotAddr(input int s);
    return (s < BANK_N) ? byte_t'(s) : ADDR_AUDIO;
  endfunction

  logic [SLOT_N-1:0][7:0] slotQ;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    byte_t q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  q <= '0;
      else if (cmd.wr && cmd.addr == slotAddr(s)) q <= cmd.data;
    end
    assign slotQ[s] = q;
  end

  logic [3:0] enQ, boostQ, threshQ;
  logic       testEnQ, testStartQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= ENABLE_RST;
      boostQ     <= BOOST_RST;
      threshQ    <= THRESH_RST;
      testEnQ    <= 1'b0;
      testStartQ <= 1'b0;
    end else begin
      testStartQ <= cmd.wr && cmd.addr == ADDR_TEST && cmd.data[0];
      if (cmd.wr) begin
        case (cmd.addr)
          ADDR_ENABLE: enQ     <= cmd.data[3:0];
          ADDR_BOOST:  boostQ  <= cmd.data[3:0];
          ADDR_THRESH: threshQ <= cmd.data[3:0];
          ADDR_TEST:   testEnQ <= cmd.data[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData  = '0;
    addrHit = 1'b0;
    for (int s = 0; s < SLOT_N; s++) begin
      if (cmd.addr == slotAddr(s)) begin
        rdData  = slotQ[s];
        addrHit = 1'b1;
      end
    end
    case (cmd.addr)
      ADDR_ENABLE: begin rdData = {4'b0, enQ};     addrHit = 1'b1; end
      ADDR_BOOST:  begin rdData = {4'b0, boostQ};  addrHit = 1'b1; end
      ADDR_THRESH: begin rdData = {4'b0, threshQ}; addrHit = 1'b1; end
      ADDR_TEST:   begin rdData = {2'b0, testStatus, testEnQ}; addrHit = 1'b1; end
      default: ;
    endcase
  end

  assign bankRegs  = slotQ;
  assign enables   = enQ;
  assign boostCode = boostQ;
  assign threshold = threshQ;
  assign testEn    = testEnQ;
  assign testStart = testStartQ;
endmodule

// File: rtl/ctrl_i2c_slave.sv
`timescale 1ns/1ps
module ctrl_i2c_slave import i2c_slave_pkg::*; #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         FILT_LEN    = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         BANK_N      = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [STAT_W-1:0]       testStatus,
  output logic                    sdaOe,
  output logic [(BANK_N+1)*8-1:0] bankRegs,
  output logic [3:0]              enables,
  output logic [3:0]              boostCode,
  output logic [3:0]              threshold,
  output logic                    testEn,
  output logic                    testStart
);
  regCmd_t cmd;
  byte_t   rdData;
  logic    addrHit;

  i2c_bus_ctrl #(
    .DEV_ADDR(DEV_ADDR), .FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .addrHit(addrHit), .sdaOe(sdaOe), .cmd(cmd)
  );

  i2c_reg_file #(.BANK_N(BANK_N)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .testStatus(testStatus),
    .rdData(rdData), .addrHit(addrHit), .bankRegs(bankRegs),
    .enables(enables), .boostCode(boostCode), .threshold(threshold),
    .testEn(testEn), .testStart(testStart)
  );
endmodule

// File: rtl/ctrl_i2c_slave_chk.sv
`timescale 1ns/1ps
module ctrl_i2c_slave_chk #(
  parameter int BANK_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [BANK_W-1:0] bankRegs,
  input logic [3:0]        enables,
  input logic [3:0]        boostCode,
  input logic [3:0]        threshold,
  input logic              testEn,
  input logic              testStart
);
  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    !rstN |=> (enables == 4'h4 && boostCode == 4'h7 && threshold == 4'h3 &&
               bankRegs == '0 && !testEn));

  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R3
  reg_change_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({bankRegs, enables, boostCode, threshold, testEn}) |-> sdaOe);

  // R7
  test_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |=> !testStart);

  // R7
  test_pulse_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    testStart |-> sdaOe);

  // R6
  test_enable_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testEn) |-> testStart);
endmodule

bind ctrl_i2c_slave ctrl_i2c_slave_chk #(.BANK_W((BANK_N+1)*8)) u_chk (.*);

// File: tb/test_ctrl_i2c_slave.sv
`timescale 1ns/1ps
module test_ctrl_i2c_slave;
  localparam int HALF = 20;
  localparam logic [4:0] STAT = 5'b10110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sclM, sdaM;
  logic sdaOe, testEn, testStart;
  logic [47:0] bankRegs;
  logic [3:0] enables, boostCode, threshold;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaOe;

  ctrl_i2c_slave i_ctrl_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .testStatus(STAT),
    .sdaOe(sdaOe), .bankRegs(bankRegs), .enables(enables), .boostCode(boostCode),
    .threshold(threshold), .testEn(testEn), .testStart(testStart)
  );

  int checks = 0, fails = 0, testPulses = 0, sdaViolations = 0;
  bit hold = 1'b1, glitchOn = 1'b0, finished = 1'b0;

  // Behavioural register model
  logic [7:0] mBank [6];
  logic [3:0] mEn = 4'h4, mBoost = 4'h7, mThr = 4'h3;
  logic       mTestEn = 1'b0;
  initial for (int i = 0; i < 6; i++) mBank[i] = 8'h00;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] modelVec();
    return {3'b0, mBank[5], mBank[4], mBank[3], mBank[2], mBank[1], mBank[0],
            mEn, mBoost, mThr, mTestEn};
  endfunction

  function automatic int slotOf(input logic [7:0] a);
    if (a <= 8'h04) return int'(a);
    if (a == 8'h2A) return 5;
    return -1;
  endfunction

  function automatic bit mapped(input logic [7:0] a);
    return slotOf(a) >= 0 || a == 8'h0B || a == 8'h0C || a == 8'h0D || a == 8'h2B;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (slotOf(a) >= 0) return mBank[slotOf(a)];
    case (a)
      8'h0B: return {4'b0, mEn};
      8'h0D: return {4'b0, mBoost};
      8'h2B: return {4'b0, mThr};
      8'h0C: return {2'b0, STAT, mTestEn};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    if (slotOf(a) >= 0) mBank[slotOf(a)] = d;
    case (a)
      8'h0B: mEn = d[3:0];
      8'h0D: mBoost = d[3:0];
      8'h2B: mThr = d[3:0];
      8'h0C: mTestEn = d[0];
      default: ;
    endcase
  endtask

  // Clock-by-clock comparison of the register ports against the model
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && !hold) check("R3 port compare", {3'b0, bankRegs, enables, boostCode, threshold, testEn}, modelVec());
    if (rstN && testStart) testPulses++;
    if (rstN && sdaOe !== prevOe && sclM) sdaViolations++;
    prevOe = sdaOe;
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitN(HALF);
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b0; waitN(HALF/2);
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitN(HALF/2);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b0; waitN(HALF);
    sclM = 1'b0; waitN(HALF/2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitN(HALF/2);
    sclM = 1'b1; waitN(HALF);
    sdaM = 1'b1; waitN(HALF);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitN(3);
    if (glitchOn) begin sclM = 1'b1; waitN(2); sclM = 1'b0; end
    waitN(HALF/2);
    sclM = 1'b1; waitN(HALF);
    sclM = 1'b0; waitN(HALF/2);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitN(HALF/2);
    sclM = 1'b1; waitN(HALF/2);
    b = sdaBus; waitN(HALF/2);
    sclM = 1'b0; waitN(HALF/2);
  endtask

  task automatic writeByte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(a);
    ack = (a == 1'b0);
  endtask

  task automatic readByte(output logic [7:0] v, input bit mAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); v[i] = b; end
    sendBit(!mAck);
  endtask

  task automatic writeReg(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                          output bit k1, output bit k2, output bit k3);
    hold = 1'b1;
    busStart();
    writeByte({dev, 1'b0}, k1);
    writeByte(a, k2);
    writeByte(d, k3);
    busStop();
    if (dev == 7'h4C && mapped(a)) modelWrite(a, d);
    waitN(4);
    hold = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] v);
    bit k;
    busStart();
    writeByte(8'h98, k);
    writeByte(a, k);
    busRestart();
    writeByte(8'h99, k);
    readByte(v, 1'b0);
    busStop();
  endtask

  task automatic expectRead(input string tag, input logic [7:0] a);
    logic [7:0] v;
    readReg(a, v);
    check(tag, v, expRead(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit k1, k2, k3;
    int p0;
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    waitN(10);
    // R1 reset state at the ports
    check("R1 reset ports", {3'b0, bankRegs, enables, boostCode, threshold, testEn}, modelVec());
    check("R9 sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    waitN(10);
    hold = 1'b0;

    // R1 R4 R6 default readback through the bus
    expectRead("R1 read 0x0B", 8'h0B);
    expectRead("R1 read 0x0D", 8'h0D);
    expectRead("R1 read 0x2B", 8'h2B);
    expectRead("R1 read 0x00", 8'h00);
    expectRead("R1 read 0x2A", 8'h2A);
    expectRead("R6 read 0x0C", 8'h0C);

    // R3 write with acks, R4 readback
    writeReg(7'h4C, 8'h00, 8'hA5, k1, k2, k3);
    check("R3 acks", {k1, k2, k3}, 3'b111);
    expectRead("R4 read 0x00", 8'h00);
    writeReg(7'h4C, 8'h04, 8'h3C, k1, k2, k3);
    writeReg(7'h4C, 8'h2A, 8'h81, k1, k2, k3);
    expectRead("R4 read 0x04", 8'h04);
    expectRead("R4 read 0x2A", 8'h2A);

    // R8 nibble registers
    writeReg(7'h4C, 8'h0B, 8'hF9, k1, k2, k3);
    writeReg(7'h4C, 8'h0D, 8'hFA, k1, k2, k3);
    writeReg(7'h4C, 8'h2B, 8'h5E, k1, k2, k3);
    expectRead("R8 read 0x0B", 8'h0B);
    expectRead("R8 read 0x0D", 8'h0D);
    expectRead("R8 read 0x2B", 8'h2B);

    // R2 foreign device address
    writeReg(7'h4D, 8'h00, 8'h11, k1, k2, k3);
    check("R2 no ack foreign address", {k1, k2, k3}, 3'b000);
    expectRead("R2 0x00 unchanged", 8'h00);

    // R5 unmapped register
    writeReg(7'h4C, 8'h10, 8'h77, k1, k2, k3);
    check("R5 data nack unmapped", {k1, k2, k3}, 3'b110);
    expectRead("R5 read unmapped", 8'h10);

    // R6 R7 test register
    p0 = testPulses;
    writeReg(7'h4C, 8'h0C, 8'hFF, k1, k2, k3);
    check("R7 one pulse on bit0 write", testPulses - p0, 1);
    expectRead("R6 status bits read-only", 8'h0C);
    writeReg(7'h4C, 8'h0C, 8'h00, k1, k2, k3);
    check("R7 no pulse on bit0 clear", testPulses - p0, 1);
    expectRead("R6 enable cleared", 8'h0C);

    // R10 STOP before data byte
    hold = 1'b0;
    busStart();
    writeByte(8'h98, k1);
    writeByte(8'h01, k2);
    busStop();
    check("R10 partial acks", {k1, k2}, 2'b11);
    expectRead("R10 0x01 unchanged", 8'h01);
    writeReg(7'h4C, 8'h02, 8'h6B, k1, k2, k3);
    expectRead("R10 recovery write", 8'h02);

    // R11 SCL glitches inside every low phase
    glitchOn = 1'b1;
    writeReg(7'h4C, 8'h03, 8'h5A, k1, k2, k3);
    glitchOn = 1'b0;
    check("R11 acks under glitches", {k1, k2, k3}, 3'b111);
    expectRead("R11 glitch write value", 8'h03);

    // R9 data line timing
    check("R9 sdaOe changes with SCL high", sdaViolations, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule